// File: doc/BRIEF.md
# Scaled Shift-Add Unit

This execute-stage block forms a scaled array index in one step: it shifts the first source operand left by one to four places and adds the second source operand. It receives a raw 32-bit instruction word and two 64-bit operand values that have already been read from the register file. It decodes two encodings. The narrow variant keeps the low 32 bits of the sum and sign-extends them. The wide variant keeps the whole 64-bit sum.

The outputs are a destination register index, write data, a write enable and an illegal-instruction flag. All four are registered, so results appear one clock after the instruction is presented. A configuration input marks the core as limited to 32 bits. When that input is set, the wide variant is refused and raises the illegal flag. Words that do not match either encoding leave the outputs idle, so other execute units can claim them.

Top module: `scaled_index_adder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_wr_en`, `out_illegal`, `out_rd` and `out_data` are all zero.
- R2: A word is recognised only when bits [31:26] are 0, bits [10:8] are 0, and bits [5:0] equal 0x05 (narrow variant) or 0x15 (wide variant). Any other word produces neither a write nor an illegal flag.
- R3: The shift amount is the 2-bit field at bits [7:6] plus one, so field values 0, 1, 2 and 3 shift by 1, 2, 3 and 4.
- R4: The result is (`src_a` << shift) + `src_b`. On a write, `out_rd` takes bits [15:11] of the word.
- R5: The narrow variant truncates the sum to its low 32 bits and sign-extends bit 31 into bits [63:32].
- R6: The wide variant writes the full 64-bit sum, wrapping modulo 2^64.
- R7: When `narrow_cfg` is high, a valid wide-variant word raises `out_illegal` for one cycle and does not write. The narrow variant is not affected by `narrow_cfg`.
- R8: A recognised word whose destination field is zero does not assert `out_wr_en`.
- R9: `out_wr_en`, `out_illegal`, `out_rd` and `out_data` change exactly one clock after the word is sampled. `out_rd` and `out_data` hold the values of the last write until the next write.
- R10: When `in_valid` is low, the word on `instr` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Raw instruction word |
| src_a | input | 64 | Operand that is shifted |
| src_b | input | 64 | Operand that is added |
| narrow_cfg | input | 1 | Core is restricted to 32-bit operation |
| out_wr_en | output | 1 | Register write request |
| out_rd | output | 5 | Destination register index |
| out_data | output | 64 | Value to write |
| out_illegal | output | 1 | Wide variant refused under the 32-bit restriction |

## Verification
The assertions check several properties on every cycle:
- A write and an illegal flag never occur together.
- A write never targets register zero.
- Every write or illegal flag follows a valid input.
- A refusal only happens when `narrow_cfg` was set.
- Narrow results always have their upper half equal to bit 31.
- Data holds its value between writes.

Only the bench's scenarios can show that the arithmetic is correct. These include the shift for each of the four scale values, wraparound of large sums, sign-extension of negative narrow sums, and rejection of near-miss encodings such as a non-zero pad field or a wrong function code.

// File: rtl/scaled_index_adder.sv
module scaled_index_adder #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            narrow_cfg,
  output logic            out_wr_en,
  output logic [4:0]      out_rd,
  output logic [XLEN-1:0] out_data,
  output logic            out_illegal
);
  localparam int HALF = XLEN / 2;
  localparam logic [5:0] FN_NARROW = 6'h05;
  localparam logic [5:0] FN_WIDE   = 6'h15;

  logic       base_ok, hit_narrow, hit_wide, do_write, do_trap;
  logic [2:0] shamt;
  logic [4:0] dest;
  logic [XLEN-1:0] sum, narrow_res;
  logic [9:0] unused_fields;

  assign unused_fields = instr[25:16];
  assign base_ok    = (instr[31:26] == 6'd0) && (instr[10:8] == 3'd0);
  assign hit_narrow = base_ok && (instr[5:0] == FN_NARROW);
  assign hit_wide   = base_ok && (instr[5:0] == FN_WIDE);
  assign dest       = instr[15:11];
  assign shamt      = {1'b0, instr[7:6]} + 3'd1;
  assign sum        = (src_a << shamt) + src_b;
  assign narrow_res = {{HALF{sum[HALF-1]}}, sum[HALF-1:0]};

  assign do_trap  = in_valid && hit_wide && narrow_cfg;
  assign do_write = in_valid && (hit_narrow || (hit_wide && !narrow_cfg)) && (dest != 5'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_wr_en   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_data    <= '0;
    end else begin
      out_wr_en   <= do_write;
      out_illegal <= do_trap;
      if (do_write) begin
        out_rd   <= dest;
        out_data <= hit_narrow ? narrow_res : sum;
      end
    end
  end

  AST_WE_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_wr_en && out_illegal)); // R7
  AST_NO_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> (out_rd != 5'd0)); // R8
  AST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_en || out_illegal) |-> $past(in_valid)); // R10
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> $past(narrow_cfg)); // R7
  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_en && ($past(instr[5:0]) == FN_NARROW)) |-> (out_data[XLEN-1:HALF] == {HALF{out_data[HALF-1]}})); // R5
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr_en |-> ($stable(out_data) && $stable(out_rd))); // R9
endmodule

// File: tb/test_scaled_index_adder.sv
module test_scaled_index_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic narrow_cfg = 1'b0;
  logic out_wr_en, out_illegal;
  logic [4:0] out_rd;
  logic [63:0] out_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic exp_we = 0, exp_ill = 0;
  logic [4:0] exp_rd = 0;
  logic [63:0] exp_data = 0;
  string tag_cur = "R1";

  always #10 clk = ~clk;

  scaled_index_adder i_scaled_index_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .narrow_cfg(narrow_cfg),
    .out_wr_en(out_wr_en), .out_rd(out_rd), .out_data(out_data),
    .out_illegal(out_illegal));

  function automatic logic [31:0] mkw(input logic [4:0] rd, input logic [1:0] sc,
                                      input logic [5:0] fn, input logic [2:0] pad,
                                      input logic [5:0] major);
    return {major, 10'h155, rd, pad, sc, fn};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({tag_cur, " R9 wr_en"}, {63'd0, out_wr_en}, {63'd0, exp_we});
    chk({tag_cur, " R7 illegal"}, {63'd0, out_illegal}, {63'd0, exp_ill});
    chk({tag_cur, " R4 rd"}, {59'd0, out_rd}, {59'd0, exp_rd});
    chk({tag_cur, " R9 data"}, out_data, exp_data);
  endtask

  // drive at negedge; reference model predicts state after next posedge
  task automatic step(input string tag, input logic v, input logic [31:0] w,
                      input logic [63:0] a, input logic [63:0] b, input logic cfg);
    logic [63:0] s;
    logic rec_n, rec_w;
    int sh;
    @(negedge clk);
    compare_all();
    in_valid = v; instr = w; src_a = a; src_b = b; narrow_cfg = cfg; tag_cur = tag;
    sh = int'(w[7:6]) + 1;
    s = (a << sh) + b;
    rec_n = (w[31:26] == 0) && (w[10:8] == 0) && (w[5:0] == 6'h05);
    rec_w = (w[31:26] == 0) && (w[10:8] == 0) && (w[5:0] == 6'h15);
    exp_ill = v && rec_w && cfg;
    exp_we = v && (rec_n || (rec_w && !cfg)) && (w[15:11] != 0);
    if (exp_we) begin
      exp_rd = w[15:11];
      exp_data = rec_n ? {{32{s[31]}}, s[31:0]} : s;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wr_en", {63'd0, out_wr_en}, 64'd0);
    chk("R1 reset illegal", {63'd0, out_illegal}, 64'd0);
    chk("R1 reset data", out_data, 64'd0);
    rst_n = 1'b1;
    // R3 each scale value, narrow and wide
    for (int k = 0; k < 4; k++) begin
      step("R3 narrow", 1, mkw(5'd3, k[1:0], 6'h05, 3'd0, 6'd0), 64'h10, 64'h1, 0);
      step("R3 wide",   1, mkw(5'd4, k[1:0], 6'h15, 3'd0, 6'd0), 64'h0123_4567_89ab_cdef, 64'h7, 0);
    end
    step("R5 negative narrow", 1, mkw(5'd5, 2'd0, 6'h05, 3'd0, 6'd0), 64'h4000_0000, 64'h0, 0);
    step("R5 narrow high bits dropped", 1, mkw(5'd6, 2'd3, 6'h05, 3'd0, 6'd0), 64'hFFFF_0000_0800_0001, 64'h5, 0);
    step("R6 wide wrap", 1, mkw(5'd7, 2'd1, 6'h15, 3'd0, 6'd0), 64'hC000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    step("R8 rd zero", 1, mkw(5'd0, 2'd0, 6'h05, 3'd0, 6'd0), 64'h1, 64'h1, 0);
    step("R2 bad pad", 1, mkw(5'd9, 2'd0, 6'h05, 3'd2, 6'd0), 64'h1, 64'h1, 0);
    step("R2 bad func", 1, mkw(5'd9, 2'd0, 6'h25, 3'd0, 6'd0), 64'h1, 64'h1, 0);
    step("R2 bad major", 1, mkw(5'd9, 2'd0, 6'h15, 3'd0, 6'd1), 64'h1, 64'h1, 0);
    step("R7 wide refused", 1, mkw(5'd10, 2'd2, 6'h15, 3'd0, 6'd0), 64'h1, 64'h1, 1);
    step("R7 narrow allowed", 1, mkw(5'd11, 2'd2, 6'h05, 3'd0, 6'd0), 64'h3, 64'h1, 1);
    step("R7 wide refused rd0", 1, mkw(5'd0, 2'd0, 6'h15, 3'd0, 6'd0), 64'h1, 64'h1, 1);
    step("R10 invalid", 0, mkw(5'd12, 2'd0, 6'h15, 3'd0, 6'd0), 64'h55, 64'h1, 0);
    step("R9 idle", 0, 32'd0, 64'd0, 64'd0, 0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [5:0] fn;
      fn = ($urandom % 4 == 0) ? 6'($urandom) : (($urandom % 2) ? 6'h05 : 6'h15);
      w = mkw(5'($urandom), 2'($urandom), fn, ($urandom % 8 == 0) ? 3'd1 : 3'd0, 6'd0);
      step("R4 R5 R6 random", ($urandom % 5) != 0, w,
           {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 6) == 0);
    end
    step("R9 drain", 0, 32'd0, 64'd0, 64'd0, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule